// File: doc/BRIEF.md
# Global-History Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It keeps a table of two-bit saturating counters and a shift register that holds the resolved directions of the most recent conditional branches. A lookup folds that history into the branch address with a bitwise XOR to pick one counter. The upper bit of that counter is the guess. Entries have no tags and hold no target addresses, because the target of a conditional branch comes from its immediate offset. Branches whose addresses collide in the table simply share a counter.

The fetch stage presents a PC and receives a direction and the counter index that was used. The pipeline carries that index along with the branch. When the branch resolves, the execute stage returns the same index together with the real outcome. The block then moves that counter one step toward the outcome and shifts the outcome into the history register. Only conditional branches go through the update port. A lookup flagged as an unconditional direct jump is always predicted taken.

Both ports are accepted on every cycle and the block never stalls, so neither port has a ready signal. The lookup port is purely combinational. The update port is valid-qualified, and the update takes effect at the clock edge where it is presented. A lookup in that same cycle still sees the state from before the update. After reset every counter is weakly not taken and the history register is zero.

Top module: `gshare_predictor`

## Requirements
- R1: After reset every counter holds weakly not taken (value 1 of the encoding 0 strong-not-taken, 1 weak-not-taken, 2 weak-taken, 3 strong-taken) and the history register is zero, so every lookup predicts not taken.
- R2: `pred_index` equals the history register XOR the HIST_W PC bits that start at bit ALIGN_LSB (PC bits ALIGN_LSB+HIST_W-1 down to ALIGN_LSB).
- R3: For a conditional lookup, `pred_taken` is 1 exactly when the selected counter is 2 or 3.
- R4: An update moves the counter at `upd_index` up by one when `upd_taken` is 1 and down by one when it is 0, holding at 3 and at 0.
- R5: On an update the history register shifts left by one place: the outcome enters bit 0 and the oldest bit is dropped. Without an update the history register is unchanged.
- R6: An update changes only the counter named by `upd_index`, whatever the current history, and no other counter.
- R7: A single not-taken outcome on a strongly-taken counter leaves it weakly taken, so it still predicts taken.
- R8: A lookup with `lookup_uncond` high predicts taken whatever the counter holds, and still reports the index.
- R9: Lookups alone change neither the counters nor the history.
- R10: PC bits below ALIGN_LSB and above ALIGN_LSB+HIST_W-1 have no effect on the index or the prediction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lookup_pc | input | PC_W | Address of the instruction being predicted |
| lookup_uncond | input | 1 | High for an unconditional direct jump |
| pred_taken | output | 1 | Predicted direction, 1 means taken |
| pred_index | output | HIST_W | Counter index used, to be carried with the branch |
| upd_valid | input | 1 | A conditional branch has resolved this cycle |
| upd_index | input | HIST_W | Index saved from that branch's lookup |
| upd_taken | input | 1 | Resolved direction |

## Verification
The hardest state to observe is the exact level of each counter. The ports show only one bit of it, and the history moves the mapping between PC and counter after every update. The bench uses a four-bit history. After each update it sweeps all sixteen index values of the PC, with different junk in the bits that must be ignored, and compares every reported index and direction against an arithmetic model. Long runs of one outcome on a single index, followed by a single reversal, drive counters to both saturation limits and test the hysteresis step. These runs use indices chosen apart from the history, so the carried index is tested independently of the current hash.

// File: rtl/gshare_pkg.sv
package gshare_pkg;

  typedef logic [1:0] ctr_t;

  localparam ctr_t CTR_SNT = 2'd0;
  localparam ctr_t CTR_WNT = 2'd1;
  localparam ctr_t CTR_WT  = 2'd2;
  localparam ctr_t CTR_ST  = 2'd3;

  // One saturating step toward the resolved outcome.
  function automatic ctr_t ctr_step(input ctr_t cur, input logic taken);
    ctr_t nxt;
    nxt = cur;
    if (taken && cur != CTR_ST) nxt = cur + 2'd1;
    if (!taken && cur != CTR_SNT) nxt = cur - 2'd1;
    return nxt;
  endfunction

  function automatic logic ctr_dir(input ctr_t cur);
    return cur[1];
  endfunction

endpackage

// File: rtl/gshare_history.sv
module gshare_history #(
  parameter int HIST_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en,
  input  logic              shift_bit,
  output logic [HIST_W-1:0] hist
);

  logic [HIST_W-1:0] hist_q;

  generate
    if (HIST_W == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hist_q <= '0;
        else if (shift_en) hist_q <= shift_bit;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hist_q <= '0;
        else if (shift_en) hist_q <= {hist_q[HIST_W-2:0], shift_bit};
      end
    end
  endgenerate

  assign hist = hist_q;

  a_r5_new_bit_at_lsb: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> hist_q[0] == $past(shift_bit));

  a_r5_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(hist_q));

endmodule

// File: rtl/gshare_index.sv
module gshare_index #(
  parameter int HIST_W = 10
) (
  input  logic [HIST_W-1:0] pc_bits,
  input  logic [HIST_W-1:0] hist,
  output logic [HIST_W-1:0] index
);

  for (genvar b = 0; b < HIST_W; b++) begin : g_bit
    assign index[b] = pc_bits[b] ^ hist[b];
  end

endmodule

// File: rtl/gshare_table.sv
module gshare_table
  import gshare_pkg::*;
#(
  parameter int IDX_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_index,
  output ctr_t             rd_ctr,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_index,
  input  logic             wr_taken
);

  localparam int N_ENT = 1 << IDX_W;

  ctr_t cnt_q [N_ENT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int e = 0; e < N_ENT; e++) cnt_q[e] <= CTR_WNT;
    end else if (wr_en) begin
      cnt_q[wr_index] <= ctr_step(cnt_q[wr_index], wr_taken);
    end
  end

  assign rd_ctr = cnt_q[rd_index];

  // Record each write so the next cycle can compare the entry before and after it.
  logic             chk_vld;
  logic             chk_taken;
  logic [IDX_W-1:0] chk_idx;
  ctr_t             chk_old;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chk_vld   <= 1'b0;
      chk_taken <= 1'b0;
      chk_idx   <= '0;
      chk_old   <= CTR_WNT;
    end else begin
      chk_vld   <= wr_en;
      chk_taken <= wr_taken;
      chk_idx   <= wr_index;
      chk_old   <= cnt_q[wr_index];
    end
  end

  a_r4_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    chk_vld |-> (2'(cnt_q[chk_idx] - chk_old) != 2'd2));

  a_r4_never_down_on_taken: assert property (@(posedge clk) disable iff (!rst_n)
    chk_vld && chk_taken |-> cnt_q[chk_idx] >= chk_old);

  a_r4_never_up_on_not_taken: assert property (@(posedge clk) disable iff (!rst_n)
    chk_vld && !chk_taken |-> cnt_q[chk_idx] <= chk_old);

  a_r4_hold_at_top: assert property (@(posedge clk) disable iff (!rst_n)
    chk_vld && chk_taken && chk_old == CTR_ST |-> cnt_q[chk_idx] == CTR_ST);

  a_r4_hold_at_bottom: assert property (@(posedge clk) disable iff (!rst_n)
    chk_vld && !chk_taken && chk_old == CTR_SNT |-> cnt_q[chk_idx] == CTR_SNT);

  a_r7_strong_to_weak: assert property (@(posedge clk) disable iff (!rst_n)
    chk_vld && !chk_taken && chk_old == CTR_ST |-> cnt_q[chk_idx] == CTR_WT);

endmodule

// File: rtl/gshare_predictor.sv
module gshare_predictor
  import gshare_pkg::*;
#(
  parameter int PC_W      = 32,
  parameter int HIST_W    = 10,
  parameter int ALIGN_LSB = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PC_W-1:0]   lookup_pc,
  input  logic              lookup_uncond,
  output logic              pred_taken,
  output logic [HIST_W-1:0] pred_index,
  input  logic              upd_valid,
  input  logic [HIST_W-1:0] upd_index,
  input  logic              upd_taken
);

  localparam int PC_HI = ALIGN_LSB + HIST_W - 1;

  logic [HIST_W-1:0] hist;
  logic [HIST_W-1:0] pc_bits;
  logic [HIST_W-1:0] idx;
  ctr_t              sel_ctr;
  logic              unused_pc_bits;

  assign pc_bits        = lookup_pc[PC_HI:ALIGN_LSB];
  assign unused_pc_bits = ^{lookup_pc[PC_W-1:PC_HI+1], lookup_pc[ALIGN_LSB-1:0]};

  gshare_history #(.HIST_W(HIST_W)) i_hist (
    .clk       (clk),
    .rst_n     (rst_n),
    .shift_en  (upd_valid),
    .shift_bit (upd_taken),
    .hist      (hist)
  );

  gshare_index #(.HIST_W(HIST_W)) i_index (
    .pc_bits (pc_bits),
    .hist    (hist),
    .index   (idx)
  );

  gshare_table #(.IDX_W(HIST_W)) i_table (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_index (idx),
    .rd_ctr   (sel_ctr),
    .wr_en    (upd_valid),
    .wr_index (upd_index),
    .wr_taken (upd_taken)
  );

  assign pred_index = idx;
  assign pred_taken = lookup_uncond | ctr_dir(sel_ctr);

  a_r8_uncond_taken: assert property (@(posedge clk) disable iff (!rst_n)
    lookup_uncond |-> pred_taken);

endmodule

// File: tb/test_gshare_predictor.sv
module test_gshare_predictor;

  localparam int CLK_PERIOD = 10;
  localparam int PC_W       = 16;
  localparam int HW         = 4;
  localparam int AL         = 2;
  localparam int NE         = 1 << HW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [PC_W-1:0] lookup_pc = '0;
  logic          lookup_uncond = 1'b0;
  logic          pred_taken;
  logic [HW-1:0] pred_index;
  logic          upd_valid = 1'b0;
  logic [HW-1:0] upd_index = '0;
  logic          upd_taken = 1'b0;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [1:0]    m_ctr [NE];
  logic [HW-1:0] m_hist;

  always #(CLK_PERIOD/2) clk = ~clk;

  gshare_predictor #(.PC_W(PC_W), .HIST_W(HW), .ALIGN_LSB(AL)) i_gshare_predictor (
    .clk           (clk),
    .rst_n         (rst_n),
    .lookup_pc     (lookup_pc),
    .lookup_uncond (lookup_uncond),
    .pred_taken    (pred_taken),
    .pred_index    (pred_index),
    .upd_valid     (upd_valid),
    .upd_index     (upd_index),
    .upd_taken     (upd_taken)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Lookup every index value; junk is placed in the ignored PC bits (R10).
  task automatic sweep(input string req, input bit uncond, input int salt);
    for (int p = 0; p < NE; p++) begin
      logic [HW-1:0] e_idx;
      logic [PC_W-1:0] pc;
      @(negedge clk);
      pc = PC_W'((p + salt * 5) * 977);
      pc[AL+HW-1:AL] = HW'(p);
      lookup_pc = pc;
      lookup_uncond = uncond;
      #1;
      e_idx = HW'(p) ^ m_hist;
      check({req, " R2 R10 index"}, int'(pred_index), int'(e_idx));
      check({req, " R3 R8 direction"}, int'(pred_taken), uncond ? 1 : int'(m_ctr[e_idx][1]));
    end
    lookup_uncond = 1'b0;
  endtask

  task automatic update(input logic [HW-1:0] idx, input bit taken);
    @(negedge clk);
    upd_valid = 1'b1;
    upd_index = idx;
    upd_taken = taken;
    @(posedge clk);
    #1;
    upd_valid = 1'b0;
    if (taken && m_ctr[idx] != 2'd3) m_ctr[idx] = m_ctr[idx] + 2'd1;
    if (!taken && m_ctr[idx] != 2'd0) m_ctr[idx] = m_ctr[idx] - 2'd1;
    m_hist = {m_hist[HW-2:0], taken};
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int e = 0; e < NE; e++) m_ctr[e] = 2'd1;
    m_hist = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1: reset state, every lookup not taken
    sweep("R1 reset", 1'b0, 0);
    // R8: unconditional lookups always taken
    sweep("R8 uncond", 1'b1, 1);

    // R4 R7: saturate index 5 high, then one not-taken step
    for (int k = 0; k < 5; k++) update(HW'(5), 1'b1);
    sweep("R4 saturate high", 1'b0, 2);
    update(HW'(5), 1'b0);
    sweep("R7 hysteresis", 1'b0, 3);
    // R4: saturate index 9 low, then one taken step
    for (int k = 0; k < 4; k++) update(HW'(9), 1'b0);
    update(HW'(9), 1'b1);
    sweep("R4 saturate low", 1'b0, 4);

    // R9: lookups only, state unchanged
    sweep("R9 lookup only", 1'b0, 5);
    sweep("R9 lookup only again", 1'b0, 6);

    // R5 R6: mixed outcomes on indices unrelated to history
    for (int k = 0; k < 120; k++) begin
      update(HW'((k * 7 + 3) % NE), ((k * 5) % 7) < 4);
      sweep("R5 R6 mixed", 1'b0, k + 7);
    end
    sweep("R8 uncond late", 1'b1, 200);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule